// File: doc/BRIEF.md
# Eight-Output Addressable Latch and Demultiplexer

This block holds eight single-bit storage cells chosen by a three-bit select. Two active-low control inputs form a mode code. The block can write one selected bit, freeze all bits, act as a one-of-eight demultiplexer that clears every output except the selected one, or clear the whole bank. It is a clocked form of a level-sensitive part. The write qualifier is sampled on the rising clock edge, and the outputs come straight from the storage register.

Typical uses are driving scattered single-bit control lines from a narrow serial-style source, and steering one data bit onto one of eight lines. In the second case the demultiplexed pattern can be frozen by moving to hold mode.

Top module: `addr_latch8`

## Requirements
- R1: While `rst_ni` is low, `bits_o` is all zeros at once, with no clock edge needed.
- R2: Write mode (`wr_ni`=0, `clr_ni`=1): at the rising edge, bit `sel_i` of `bits_o` takes `din_i` and every other bit keeps its value.
- R3: Hold mode (`wr_ni`=1, `clr_ni`=1): at the rising edge, `bits_o` is unchanged whatever `sel_i` and `din_i` carry.
- R4: Demultiplexer mode (`wr_ni`=0, `clr_ni`=0): at the rising edge, bit `sel_i` takes `din_i` and the other seven bits become 0.
- R5: Clear mode (`wr_ni`=1, `clr_ni`=0): at the rising edge, all bits become 0 whatever `sel_i` and `din_i` carry.
- R6: `sel_i` is an unsigned binary index with bit 0 as the LSB. Value k addresses `bits_o[k]`, so 0 selects bit 0 and 7 selects bit 7.
- R7: A pattern written in demultiplexer mode is kept unchanged through any following cycles in hold mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the register updates on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the register |
| wr_ni | input | 1 | Active-low write qualifier (mode code bit) |
| clr_ni | input | 1 | Active-low clear control (mode code bit) |
| sel_i | input | 3 | Bit select index |
| din_i | input | 1 | Data bit |
| bits_o | output | 8 | Stored bits |

## Verification
Every synchronous result is due at the first rising edge after the inputs are applied. The bench therefore drives inputs on the falling edge and compares `bits_o` 1 ns after the next rising edge against a bench-side model that was advanced by exactly one step. The asynchronous reset result is due with no edge at all. It is sampled 1 ns after `rst_ni` falls, in the middle of a clock phase.

// File: rtl/addr_latch8_pkg.sv
`timescale 1ns/1ps
package addr_latch8_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE = 2'b00,
    MODE_HOLD  = 2'b01,
    MODE_DEMUX = 2'b10,
    MODE_CLEAR = 2'b11
  } mode_e;
endpackage

// File: rtl/addr_latch8_mode.sv
`timescale 1ns/1ps
module addr_latch8_mode
  import addr_latch8_pkg::*;
(
  input  logic  wr_ni,
  input  logic  clr_ni,
  output mode_e mode_o
);
  always_comb begin
    unique case ({wr_ni, clr_ni})
      2'b01:   mode_o = MODE_WRITE;
      2'b11:   mode_o = MODE_HOLD;
      2'b00:   mode_o = MODE_DEMUX;
      default: mode_o = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/addr_latch8_dec.sv
`timescale 1ns/1ps
module addr_latch8_dec #(
  parameter int SEL_W  = 3,
  localparam int N_OUT = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [N_OUT-1:0] hit_o
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_hit
    assign hit_o[k] = (sel_i == SEL_W'(k));
  end
endmodule

// File: rtl/addr_latch8_bank.sv
`timescale 1ns/1ps
module addr_latch8_bank
  import addr_latch8_pkg::*;
#(
  parameter int N_BITS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mode_e             mode_i,
  input  logic [N_BITS-1:0] hit_i,
  input  logic              din_i,
  output logic [N_BITS-1:0] q_o
);
  for (genvar k = 0; k < N_BITS; k++) begin : g_cell
    logic q_d, q_q;

    always_comb begin
      unique case (mode_i)
        MODE_WRITE: q_d = hit_i[k] ? din_i : q_q;
        MODE_HOLD:  q_d = q_q;
        MODE_DEMUX: q_d = hit_i[k] & din_i;
        default:    q_d = 1'b0;
      endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q <= 1'b0;
      else         q_q <= q_d;
    end

    assign q_o[k] = q_q;
  end
endmodule

// File: rtl/addr_latch8.sv
`timescale 1ns/1ps
module addr_latch8
  import addr_latch8_pkg::*;
#(
  parameter int SEL_W   = 3,
  localparam int N_BITS = 1 << SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ni,
  input  logic              clr_ni,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              din_i,
  output logic [N_BITS-1:0] bits_o
);
  mode_e             mode;
  logic [N_BITS-1:0] hit;

  addr_latch8_mode i_mode (
    .wr_ni  (wr_ni),
    .clr_ni (clr_ni),
    .mode_o (mode)
  );

  addr_latch8_dec #(.SEL_W(SEL_W)) i_dec (
    .sel_i (sel_i),
    .hit_o (hit)
  );

  addr_latch8_bank #(.N_BITS(N_BITS)) i_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .hit_i  (hit),
    .din_i  (din_i),
    .q_o    (bits_o)
  );
endmodule

// File: rtl/addr_latch8_chk.sv
`timescale 1ns/1ps
module addr_latch8_chk #(
  parameter int SEL_W   = 3,
  localparam int N_BITS = 1 << SEL_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_ni,
  input logic              clr_ni,
  input logic [SEL_W-1:0]  sel_i,
  input logic              din_i,
  input logic [N_BITS-1:0] bits_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) p_reset_zero_r1: assert (bits_o == '0);
  end

  p_write_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ni && clr_ni) |=> bits_o[$past(sel_i)] == $past(din_i));

  p_write_others_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ni && clr_ni) |=>
      (((bits_o ^ $past(bits_o)) & ~(N_BITS'(1) << $past(sel_i))) == '0));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ni && clr_ni) |=> $stable(bits_o));

  p_demux_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ni && !clr_ni) |=> bits_o == (N_BITS'($past(din_i)) << $past(sel_i)));

  p_demux_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ni && !clr_ni) |=> $countones(bits_o) == int'($past(din_i)));

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ni && !clr_ni) |=> bits_o == '0);
endmodule

bind addr_latch8 addr_latch8_chk #(.SEL_W(SEL_W)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_ni  (wr_ni),
  .clr_ni (clr_ni),
  .sel_i  (sel_i),
  .din_i  (din_i),
  .bits_o (bits_o)
);

// File: tb/test_addr_latch8.sv
`timescale 1ns/1ps
module test_addr_latch8;
  localparam int SEL_W  = 3;
  localparam int N_BITS = 1 << SEL_W;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_ni = 1'b1;
  logic              clr_ni = 1'b1;
  logic [SEL_W-1:0]  sel_i = '0;
  logic              din_i = 1'b0;
  logic [N_BITS-1:0] bits_o;

  int checks = 0;
  int errors = 0;
  logic [N_BITS-1:0] exp_q = '0;
  bit done = 0;

  always #2 clk = ~clk;

  addr_latch8 #(.SEL_W(SEL_W)) i_addr_latch8 (
    .clk_i (clk), .rst_ni (rst_ni), .wr_ni (wr_ni), .clr_ni (clr_ni),
    .sel_i (sel_i), .din_i (din_i), .bits_o (bits_o)
  );

  function automatic logic [N_BITS-1:0] model(logic w, logic c, logic [SEL_W-1:0] s,
                                              logic d, logic [N_BITS-1:0] cur);
    logic [N_BITS-1:0] r;
    r = cur;
    case ({w, c})
      2'b01: r[s] = d;
      2'b11: r = cur;
      2'b00: r = N_BITS'(d) << s;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(logic w, logic c);
    case ({w, c})
      2'b01:   return "R2 write";
      2'b11:   return "R3 hold";
      2'b00:   return "R4 demux";
      default: return "R5 clear";
    endcase
  endfunction

  task automatic check(string req, logic [N_BITS-1:0] act, logic [N_BITS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: bits_o=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(logic w, logic c, logic [SEL_W-1:0] s, logic d, string req);
    @(negedge clk);
    wr_ni = w; clr_ni = c; sel_i = s; din_i = d;
    exp_q = model(w, c, s, d, exp_q);
    @(posedge clk);
    #1;
    check(req, bits_o, exp_q);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic w, c, d;
    logic [SEL_W-1:0] s;
    void'($urandom(32'h5eed_1234));
    #7;
    check("R1 reset state", bits_o, '0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R6: each index addresses its own bit, LSB first
    for (int k = 0; k < N_BITS; k++) begin
      step(1'b0, 1'b1, SEL_W'(k), 1'b1, "R6 index order");
      check("R6 single bit", bits_o, N_BITS'((1 << (k + 1)) - 1));
    end
    step(1'b0, 1'b1, 3'd3, 1'b0, "R2 write clear one bit");
    step(1'b1, 1'b1, 3'd3, 1'b1, "R3 hold ignores din");
    step(1'b1, 1'b1, 3'd5, 1'b0, "R3 hold ignores sel");
    step(1'b1, 1'b0, 3'd2, 1'b1, "R5 clear");
    // demux every index, then hold retains the pattern
    for (int k = 0; k < N_BITS; k++) begin
      step(1'b0, 1'b0, SEL_W'(k), 1'b1, "R4 demux one-hot");
      check("R6 demux index", bits_o, N_BITS'(1) << k);
    end
    step(1'b0, 1'b0, 3'd6, 1'b1, "R4 demux");
    for (int k = 0; k < 4; k++)
      step(1'b1, 1'b1, SEL_W'($urandom), 1'($urandom), "R7 demux pattern kept");
    check("R7 kept value", bits_o, 8'b0100_0000);
    step(1'b0, 1'b0, 3'd1, 1'b0, "R4 demux zero data");

    // random mix of all four mode codes
    for (int n = 0; n < 600; n++) begin
      w = 1'($urandom); c = 1'($urandom);
      s = SEL_W'($urandom); d = 1'($urandom);
      step(w, c, s, d, tag_of(w, c));
    end

    // asynchronous reset mid-phase
    for (int k = 0; k < N_BITS; k++) step(1'b0, 1'b1, SEL_W'(k), 1'b1, "R2 fill");
    @(negedge clk);
    wr_ni = 1'b1; clr_ni = 1'b1;
    #0.5 rst_ni = 1'b0;
    #1;
    exp_q = '0;
    check("R1 async reset", bits_o, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    step(1'b1, 1'b1, 3'd0, 1'b1, "R3 hold after reset");
    finish_run();
  end
endmodule